// File: doc/BRIEF.md
# Burst-capable DRAM array controller

This controller sits between a 32-bit synchronous CPU bus and a dynamic RAM array. It serves single reads and writes of one, two or four bytes, and it serves cache-line fills of four longwords. A fill returns one beat in the fifth clock and then one beat in each of the next three clocks, so a 16-byte line takes eight clocks. The CPU holds a request level with its address, write flag, burst flag, byte enables and write data. It drops the request in the cycle after the final acknowledge, or in the cycle after a bus error.

A three-bit capacity code sets the size of the installed array, and that size sets the decoded window. The window always starts at byte address 0. An access outside the window, or an access made while the code is reserved, gets a bus error and sends nothing to the DRAM. A free-running interval counter requests a refresh of one row at a time. The controller grants a refresh only when no CPU transaction is in flight. A CPU access that meets a pending refresh therefore waits a bounded number of clocks.

The DRAM side is a command port with a word address, byte enables and write data. Read data comes back on `dram_rdata` in the clock after the read command.

Top module: `dram_burst_ctrl`

## Requirements
- R1: A single read or write is acknowledged by exactly one `cpu_ack` pulse. The pulse is in the 5th clock, counting the clock in which the controller first sees the request while idle as clock 1. During a read acknowledge, `cpu_rdata` carries `dram_rdata`.
- R2: A read with `cpu_burst`=1 gives four `cpu_ack` pulses in clocks 5, 6, 7 and 8. Beat i reads word `(A[3:2]+i) mod 4` of the 16-byte line that holds byte address A. The word-address bits above bit 1 stay fixed.
- R3: When `cpu_wr`=1, the burst flag has no effect. The write gets one acknowledge in clock 5 and one write command.
- R4: A refresh request becomes pending every REF_INTERVAL clocks, the first one REF_INTERVAL clocks after reset. Each granted refresh issues one REF command (code 4). Its `dram_addr` is a row number that starts at 0 after reset and rises by 1 per refresh, modulo 2^ROW_BITS.
- R5: A refresh is granted only from idle, never between the acceptance of an access and its final acknowledge. A granted refresh keeps the controller busy for 4 clocks. A request that arrives in an idle clock while a refresh is pending is acknowledged exactly 5 clocks later than it would be otherwise.
- R6: Capacity codes 000, 001, 010 and 011 decode windows of 32, 16, 8 and 4 MB from address 0. For an address at or above the window end, `cpu_err` pulses for one clock in clock 2, with no acknowledge and no DRAM command.
- R7: A capacity code with bit 2 set is reserved. Every access made under it ends with the `cpu_err` pulse of R6.
- R8: DRAM commands are encoded NOP=0, ACT=1, RD=2, WR=3, REF=4. An access issues ACT in clock 2 with the word address (byte address bits 24..2). A read issues RD in clock 4. A write issues WR in clock 5, carrying the request's byte enables and write data.
- R9: During and right after reset, `cpu_ack` and `cpu_err` are 0 and `dram_cmd` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_code | input | 3 | Installed capacity code |
| cpu_req | input | 1 | Access request, held until the last acknowledge or the error |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_burst | input | 1 | Line-fill request (reads only) |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte enables |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Beat acknowledge |
| cpu_err | output | 1 | Bus error |
| cpu_rdata | output | 32 | Read data |
| dram_cmd | output | 3 | DRAM command code |
| dram_addr | output | 23 | Word address, or row number for REF |
| dram_be | output | 4 | Byte enables for WR |
| dram_wdata | output | 32 | Write data for WR |
| dram_rdata | input | 32 | Read data, valid the clock after RD |

## Verification
A wrong phase counter shows up at the ports at once. The command stream shifts by a clock, or an acknowledge lands outside clock 5, and the per-clock comparison reports it at the first access. A wrong beat index or line wrap shows up as a wrong `dram_addr` on a read command, one clock before the bad data reaches `cpu_rdata`. Faults in the refresh timer or the pending flag show up at the first refresh, a few hundred clocks after reset, as a REF command in the wrong clock. A deliberate request in a cycle where a refresh is pending then confirms that the stall is exactly five clocks.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_REF = 3'd4
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_ACC,
        ST_BURST,
        ST_ERR
    } seq_state_e;
endpackage

// File: rtl/dbc_decode.sv
module dbc_decode #(
    parameter int ADDR_W   = 32,
    parameter int MAX_LOG2 = 25,
    parameter int CODE_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] cap_code,
    output logic              hit
);
    localparam int SEL_W = CODE_W - 1;
    localparam int NCODE = 1 << SEL_W;

    logic [NCODE-1:0] fits;

    // one window per non-reserved code, each half the previous one
    for (genvar k = 0; k < NCODE; k++) begin : g_win
        localparam int LIM = MAX_LOG2 - k;
        localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(64'd1 << LIM);
        assign fits[k] = (addr < LIMIT);
    end

    assign hit = !cap_code[CODE_W-1] && fits[cap_code[SEL_W-1:0]];
endmodule

// File: rtl/dbc_refresh_timer.sv
module dbc_refresh_timer #(
    parameter int INTERVAL = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic pend
);
    localparam int TW = $clog2(INTERVAL);
    localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t q, d;
    logic expire;

    always_comb begin
        d      = q;
        expire = (q.cnt == '0);
        d.cnt  = expire ? RELOAD : q.cnt - 1'b1;
        d.pend = (q.pend && !grant) || expire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt  <= RELOAD;
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pend = q.pend;

    // a pending refresh is only dropped by a grant
    assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !grant) |=> pend);
    // a grant is only given against a pending request
    assert_grant_needs_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pend);
endmodule

// File: rtl/dbc_seq.sv
module dbc_seq
    import dbc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DAW        = 23,
    parameter int REF_CYCLES = 4,
    parameter int ACC_CLOCKS = 5,
    parameter int BEATS      = 4,
    parameter int ROW_BITS   = 12,
    localparam int BE_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic              burst,
    input  logic [DAW-1:0]    word,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    input  logic              pend,
    output logic              grant,
    output logic              ack,
    output logic              err,
    output logic [2:0]        cmd_o,
    output logic [DAW-1:0]    addr_o,
    output logic [BE_W-1:0]   be_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam int LINE_W = $clog2(BEATS);
    localparam int MAXC   = (REF_CYCLES > ACC_CLOCKS) ? REF_CYCLES : ACC_CLOCKS;
    localparam int CNT_W  = $clog2(MAXC) + 1;
    localparam logic [CNT_W-1:0]  ACT_AT    = CNT_W'(1);
    localparam logic [CNT_W-1:0]  RD_AT     = CNT_W'(ACC_CLOCKS - 2);
    localparam logic [CNT_W-1:0]  ACK_AT    = CNT_W'(ACC_CLOCKS - 1);
    localparam logic [CNT_W-1:0]  REF_LAST  = CNT_W'(REF_CYCLES - 1);
    localparam logic [LINE_W-1:0] LAST_BEAT = LINE_W'(BEATS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [LINE_W-1:0] beat;
        logic              wr;
        logic              burst;
        logic [DAW-1:0]    word;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
        logic [ROW_BITS-1:0] row;
    } seq_t;

    seq_t q, d;
    dram_cmd_e cmd;
    logic [LINE_W-1:0] rd_beat;

    // next-state
    always_comb begin
        d     = q;
        grant = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (pend) begin
                    d.state = ST_REF;
                    d.cnt   = '0;
                    grant   = 1'b1;
                end else if (req) begin
                    if (!hit) begin
                        d.state = ST_ERR;
                    end else begin
                        d.state = ST_ACC;
                        d.cnt   = ACT_AT;
                        d.wr    = wr;
                        d.burst = burst && !wr;
                        d.word  = word;
                        d.be    = (burst && !wr) ? '1 : be;
                        d.wdata = wdata;
                    end
                end
            end
            ST_REF: begin
                if (q.cnt == REF_LAST) begin
                    d.state = ST_IDLE;
                    d.row   = q.row + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_ACC: begin
                if (q.cnt == ACK_AT) begin
                    d.state = q.burst ? ST_BURST : ST_IDLE;
                    d.beat  = LINE_W'(1);
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_BURST: begin
                if (q.beat == LAST_BEAT) d.state = ST_IDLE;
                else                     d.beat  = q.beat + 1'b1;
            end
            ST_ERR:  d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    // outputs from the current phase
    always_comb begin
        cmd     = CMD_NOP;
        rd_beat = '0;
        addr_o  = q.word;
        unique case (q.state)
            ST_REF: if (q.cnt == '0) cmd = CMD_REF;
            ST_ACC: begin
                if (q.cnt == ACT_AT) begin
                    cmd = CMD_ACT;
                end else if (q.cnt == RD_AT && !q.wr) begin
                    cmd = CMD_RD;
                end else if (q.cnt == ACK_AT && q.wr) begin
                    cmd = CMD_WR;
                end else if (q.cnt == ACK_AT && q.burst) begin
                    cmd     = CMD_RD;
                    rd_beat = LINE_W'(1);
                end
            end
            ST_BURST: begin
                if (q.beat != LAST_BEAT) begin
                    cmd     = CMD_RD;
                    rd_beat = q.beat + 1'b1;
                end
            end
            default: cmd = CMD_NOP;
        endcase
        if (cmd == CMD_REF) addr_o = DAW'(q.row);
        if (cmd == CMD_RD)  addr_o = {q.word[DAW-1:LINE_W], q.word[LINE_W-1:0] + rd_beat};
    end

    assign ack     = (q.state == ST_ACC && q.cnt == ACK_AT) || (q.state == ST_BURST);
    assign err     = (q.state == ST_ERR);
    assign cmd_o   = cmd;
    assign be_o    = q.be;
    assign wdata_o = q.wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assert_ack_err_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && err));
    // first beat of a fill is followed directly by the next beat
    assert_burst_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && q.state == ST_ACC && q.burst) |=> ack);
    // a write gets a single acknowledge
    assert_write_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |=> !ack);
    // a refresh command is followed by quiet clocks
    assert_ref_then_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |=> (cmd == CMD_NOP && !ack));
    // an error is one clock long and touches no DRAM
    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && cmd == CMD_NOP));
    // every first acknowledge was opened by an activate three clocks before
    assert_act_before_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !$past(ack)) |-> ($past(cmd, 3) == CMD_ACT));
endmodule

// File: rtl/dram_burst_ctrl.sv
module dram_burst_ctrl #(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int MAX_LOG2     = 25,
    parameter int CODE_W       = 3,
    parameter int REF_INTERVAL = 350,
    parameter int REF_CYCLES   = 4,
    parameter int ACC_CLOCKS   = 5,
    parameter int BEATS        = 4,
    parameter int ROW_BITS     = 12,
    localparam int BE_W        = DATA_W / 8,
    localparam int OFF_W       = $clog2(BE_W),
    localparam int DAW         = MAX_LOG2 - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cap_code,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic              cpu_burst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic              cpu_err,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [2:0]        dram_cmd,
    output logic [DAW-1:0]    dram_addr,
    output logic [BE_W-1:0]   dram_be,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    logic hit, pend, grant;

    dbc_decode #(
        .ADDR_W  (ADDR_W),
        .MAX_LOG2(MAX_LOG2),
        .CODE_W  (CODE_W)
    ) u_decode (
        .addr    (cpu_addr),
        .cap_code(cap_code),
        .hit     (hit)
    );

    dbc_refresh_timer #(
        .INTERVAL(REF_INTERVAL)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .grant(grant),
        .pend (pend)
    );

    dbc_seq #(
        .DATA_W    (DATA_W),
        .DAW       (DAW),
        .REF_CYCLES(REF_CYCLES),
        .ACC_CLOCKS(ACC_CLOCKS),
        .BEATS     (BEATS),
        .ROW_BITS  (ROW_BITS)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (cpu_req),
        .wr     (cpu_wr),
        .burst  (cpu_burst),
        .word   (cpu_addr[MAX_LOG2-1:OFF_W]),
        .be     (cpu_be),
        .wdata  (cpu_wdata),
        .hit    (hit),
        .pend   (pend),
        .grant  (grant),
        .ack    (cpu_ack),
        .err    (cpu_err),
        .cmd_o  (dram_cmd),
        .addr_o (dram_addr),
        .be_o   (dram_be),
        .wdata_o(dram_wdata)
    );

    assign cpu_rdata = dram_rdata;

    // an error only answers a live request
    assert_err_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> $past(cpu_req));
endmodule

// File: tb/sim_dram_burst_ctrl.sv
module sim_dram_burst_ctrl;
    localparam int INTERVAL = 350;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cap_code = 3'd0;
    logic        cpu_req = 1'b0, cpu_wr = 1'b0, cpu_burst = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = 4'hF;
    logic        cpu_ack, cpu_err;
    logic [31:0] cpu_rdata, dram_wdata;
    logic [2:0]  dram_cmd;
    logic [22:0] dram_addr;
    logic [3:0]  dram_be;
    logic [31:0] dram_rdata = '0;

    always #5 clk = ~clk;

    dram_burst_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cap_code(cap_code),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_burst(cpu_burst),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
        .dram_cmd(dram_cmd), .dram_addr(dram_addr), .dram_be(dram_be),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    int nvec = 0, nfail = 0;
    bit finished = 1'b0;

    // DRAM behaviour in the bench
    logic [31:0] mem [int];
    function automatic logic [31:0] mem_rd(int w);
        if (mem.exists(w)) return mem[w];
        return (32'(w) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    always @(posedge clk) begin
        if (dram_cmd == 3'd2) dram_rdata <= mem_rd(int'(dram_addr));
        if (dram_cmd == 3'd3) begin
            logic [31:0] cur;
            cur = mem_rd(int'(dram_addr));
            for (int b = 0; b < 4; b++)
                if (dram_be[b]) cur[8*b +: 8] = dram_wdata[8*b +: 8];
            mem[int'(dram_addr)] = cur;
        end
    end

    // reference model: expectations keyed by cycle number
    int          cyc = 0;
    int          busy_until = 0;
    int          m_cnt = INTERVAL - 1;
    bit          m_pend = 1'b0;
    int          m_row = 0;
    int          e_cmd [int];
    int          e_addr [int];
    logic [3:0]  e_be [int];
    logic [31:0] e_wd [int];
    logic [31:0] e_rd [int];
    string       e_atag [int];
    string       e_etag [int];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic tick();
        int c = cyc;
        int xc = e_cmd.exists(c) ? e_cmd[c] : 0;
        bit xa = e_atag.exists(c);
        bit xe = e_etag.exists(c);
        bit grant = 1'b0;
        bit expire;
        chk(int'(dram_cmd) == xc, (xc == 4) ? "R4" : "R8", "dram_cmd", dram_cmd, xc);
        chk(cpu_ack == xa, xa ? e_atag[c] : "R1", "cpu_ack", cpu_ack, xa);
        chk(cpu_err == xe, xe ? e_etag[c] : "R6", "cpu_err", cpu_err, xe);
        if (xc != 0) chk(int'(dram_addr) == e_addr[c], (xc == 4) ? "R4" : "R8", "dram_addr", dram_addr, e_addr[c]);
        if (xc == 3) begin
            chk(dram_be == e_be[c], "R8", "dram_be", dram_be, e_be[c]);
            chk(dram_wdata == e_wd[c], "R8", "dram_wdata", dram_wdata, e_wd[c]);
        end
        if (e_rd.exists(c)) chk(cpu_rdata == e_rd[c], e_atag[c], "cpu_rdata", cpu_rdata, e_rd[c]);

        // model step for this cycle
        if (c >= busy_until) begin
            if (m_pend) begin
                grant = 1'b1;
                e_cmd[c+1] = 4; e_addr[c+1] = m_row;
                m_row = (m_row + 1) % 4096;
                busy_until = c + 5;
            end else if (cpu_req) begin
                bit bad = cap_code[2] || ((cpu_addr >> (25 - int'(cap_code[1:0]))) != 0);
                if (bad) begin
                    e_etag[c+1] = cap_code[2] ? "R7" : "R6";
                    busy_until = c + 2;
                end else begin
                    int w = int'((cpu_addr >> 2) & 32'h7FFFFF);
                    e_cmd[c+1] = 1; e_addr[c+1] = w;
                    if (cpu_wr) begin
                        e_cmd[c+4] = 3; e_addr[c+4] = w; e_be[c+4] = cpu_be; e_wd[c+4] = cpu_wdata;
                        e_atag[c+4] = cpu_burst ? "R3" : "R1";
                        busy_until = c + 5;
                    end else if (cpu_burst) begin
                        for (int i = 0; i < 4; i++) begin
                            int wi = (w & ~3) | ((w + i) & 3);
                            e_cmd[c+3+i] = 2; e_addr[c+3+i] = wi;
                            e_atag[c+4+i] = "R2"; e_rd[c+4+i] = mem_rd(wi);
                        end
                        busy_until = c + 8;
                    end else begin
                        e_cmd[c+3] = 2; e_addr[c+3] = w;
                        e_atag[c+4] = "R1"; e_rd[c+4] = mem_rd(w);
                        busy_until = c + 5;
                    end
                end
            end
        end
        expire = (m_cnt == 0);
        m_cnt  = expire ? INTERVAL - 1 : m_cnt - 1;
        m_pend = (m_pend && !grant) || expire;

        @(negedge clk);
        cyc++;
    endtask

    task automatic access(input logic [31:0] a, input bit wr, input bit bur,
                          input logic [3:0] be, input logic [31:0] wd,
                          output int first, output int last);
        int start = cyc;
        int acks = 0;
        int need = (bur && !wr) ? 4 : 1;
        first = -1; last = -1;
        cpu_req = 1'b1; cpu_wr = wr; cpu_burst = bur; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        for (int n = 0; n < 60; n++) begin
            bit done = 1'b0;
            if (cpu_err) begin first = cyc - start; last = first; done = 1'b1; end
            if (cpu_ack) begin
                acks++;
                if (first < 0) first = cyc - start;
                last = cyc - start;
                if (acks == need) done = 1'b1;
            end
            tick();
            if (done) break;
        end
        cpu_req = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int f, l;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk(cpu_ack == 1'b0, "R9", "cpu_ack in reset", cpu_ack, 0);
            chk(cpu_err == 1'b0, "R9", "cpu_err in reset", cpu_err, 0);
            chk(dram_cmd == 3'd0, "R9", "dram_cmd in reset", dram_cmd, 0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        cyc = 0;

        // writes, including partial enables and a burst-flagged write (R3)
        access(32'h10, 1, 0, 4'hF, 32'h1111_0010, f, l);
        chk(f == 4, "R1", "write latency", f, 4);
        access(32'h14, 1, 0, 4'hF, 32'h2222_0014, f, l);
        access(32'h18, 1, 0, 4'b0011, 32'hABCD_3318, f, l);
        access(32'h1C, 1, 1, 4'b1100, 32'h4444_001C, f, l);
        chk(f == 4 && l == 4, "R3", "burst-flag write beats", l, 4);
        access(32'h01FF_FFFC, 1, 0, 4'hF, 32'hDEAD_BEEF, f, l);

        // single reads
        access(32'h18, 0, 0, 4'hF, 0, f, l);
        chk(f == 4, "R1", "read latency", f, 4);
        access(32'h01FF_FFFC, 0, 0, 4'h1, 0, f, l);

        // line fills starting on each word of the line (R2)
        for (int s = 0; s < 4; s++) begin
            access(32'h10 + 32'(4 * s), 0, 1, 4'hF, 0, f, l);
            chk(f == 4 && l == 7, "R2", "burst beat window", l, 7);
        end
        idle(3);

        // capacity windows (R6) and reserved codes (R7)
        for (int k = 0; k < 4; k++) begin
            logic [31:0] lim = 32'h0200_0000 >> k;
            cap_code = 3'(k);
            access(lim - 4, 0, 0, 4'hF, 0, f, l);
            access(lim, 0, 0, 4'hF, 0, f, l);
            chk(f == 1, "R6", "error clock", f, 1);
        end
        for (int k = 4; k < 8; k++) begin
            cap_code = 3'(k);
            access(32'h0, 0, 0, 4'hF, 0, f, l);
            chk(f == 1, "R7", "reserved code error clock", f, 1);
        end
        cap_code = 3'd0;

        // request meets a pending refresh (R5)
        for (int r = 0; r < 2; r++) begin
            while (!m_pend) tick();
            access(32'h20, 0, r[0], 4'hF, 0, f, l);
            chk(f == 9, "R5", "refresh collision latency", f, 9);
            access(32'h24, 0, 1, 4'hF, 0, f, l);
            chk(f == 4, "R5", "latency right after refresh", f, 4);
        end

        // mixed traffic with random gaps
        for (int i = 0; i < 150; i++) begin
            logic [31:0] a = ($urandom & 32'h3FF) & ~32'h3;
            bit wr = $urandom_range(0, 2) == 0;
            bit bur = $urandom_range(0, 1) == 1;
            access(a, wr, bur, 4'($urandom), $urandom, f, l);
            idle($urandom_range(0, 3));
        end

        // quiet period: refreshes at the bare interval (R4)
        idle(3 * INTERVAL);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule